// File: doc/BRIEF.md
# Incrementing Burst Write Manager with Pause Support

This block is a single-manager AHB-Lite write engine. Software or another block hands it a command (start address, beat count, transfer size) and streams the payload into an internal write-data FIFO. The engine then issues one incrementing write burst. Each beat is an address phase followed by a data phase, and the FIFO supplies the data.

The data source may be slower than the bus. When the FIFO has no word for the next beat in the middle of a burst, the engine keeps the burst open. It marks the cycle as a pause, holds the address of the beat it still owes, and continues with a sequential beat once data arrives. If the FIFO is empty before the first beat, the bus stays idle and the start is delayed.

An error response ends the burst at once. The engine signals completion with an error flag and drops the beats that were not yet written.

Both input streams use valid/ready:
- A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is only high while the engine is fully idle.
- A data word transfers on an edge where `wd_valid` and `wd_ready` are both high. `wd_ready` drops while the FIFO is full.
- A source that sees ready low must hold its valid and payload until ready returns.

Top module: `ahb_burst_writer`

## Requirements
- R1: Transfer codes are idle 2'b00, pause 2'b01, first beat 2'b10 and sequential 2'b11. The first beat of every command, including a one-beat command, is 2'b10. The code after an idle cycle is never 2'b11 or 2'b01.
- R2: Every beat after the first is driven as 2'b11. Its address is the previous beat address plus 1 << size.
- R3: If the FIFO holds no word for the next beat inside a burst, `htrans` is 2'b01. During that pause, `haddr` holds the address of that pending beat.
- R4: After a pause the burst continues with 2'b11 at the held address, with no new first beat. Every commanded beat is written exactly once, in address order.
- R5: `htrans` is idle (2'b00) in three cases: after reset, while no command is active, and after the last beat is accepted. When the FIFO is empty at command start, the bus stays idle with no pause cycles until the first word arrives.
- R6: While `hready` is low, and no error response is in progress, `haddr`, `htrans`, `hsize` and `hburst` stay unchanged.
- R7: `hwdata` carries FIFO words in push order, one word per beat, in the data phase that follows each accepted address phase. A word leaves the FIFO only when its data phase completes with `hready` high.
- R8: `hsize` equals the command size and `hwrite` is 1. `hburst` depends on `cmd_len`:

  | `cmd_len` | beats | `hburst` |
  |---|---|---|
  | 0 | 1 | 3'b000 (single) |
  | 3 | 4 | 3'b011 (4-beat incrementing) |
  | 7 | 8 | 3'b101 (8-beat incrementing) |
  | 15 | 16 | 3'b111 (16-beat incrementing) |
  | any other | `cmd_len`+1 | 3'b001 (undefined-length incrementing) |

- R9: After reset, `cmd_ready` is 1 and `done` is 0. `done` pulses for one cycle, the cycle after the last data phase completes. `cmd_ready` is high only when no burst and no data phase are active.
- R10: On a two-cycle error response, `htrans` is idle in the second cycle. `done` and `done_err` then pulse together, and no later beat is issued. The FIFO words held at that point are discarded.
- R11: `wd_ready` is low while the FIFO holds DEPTH words. A word offered while `wd_ready` is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | AW | Address of the first beat |
| cmd_len | input | LW | Beat count minus one |
| cmd_size | input | 3 | Transfer size code; the address step is 1 << size |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | FIFO can take a word |
| wd_data | input | DW | Write word |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type code |
| hwrite | output | 1 | Write direction, always 1 |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type |
| hwdata | output | DW | Write data in the data phase |
| hready | input | 1 | Transfer completion from the subordinate |
| hresp | input | 1 | Error response |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was caused by an error |

## Verification
The bench builds the engine with a 32-bit address and data path, a 5-bit length field and an 8-entry FIFO.

The 8-entry FIFO is smaller than a 16-beat burst, so pushes and drains must overlap, and full-FIFO back-pressure can be reached with no command pending. The 5-bit length covers every fixed-length burst code as well as the undefined-length case.

The stall gaps are longer than any internal latency, so pause cycles are certain to occur at chosen beats. Wait states are placed in alternate data-phase cycles so that holds and pauses interact.

// File: rtl/ahbw_pkg.sv
`timescale 1ns/1ps
package ahbw_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_SINGLE = 3'b000;
  localparam logic [2:0] BURST_INCR   = 3'b001;
  localparam logic [2:0] BURST_INCR4  = 3'b011;
  localparam logic [2:0] BURST_INCR8  = 3'b101;
  localparam logic [2:0] BURST_INCR16 = 3'b111;

  // Burst code from the beat count minus one.
  function automatic logic [2:0] pick_burst(input logic [31:0] len_m1);
    case (len_m1)
      32'd0:   return BURST_SINGLE;
      32'd3:   return BURST_INCR4;
      32'd7:   return BURST_INCR8;
      32'd15:  return BURST_INCR16;
      default: return BURST_INCR;
    endcase
  endfunction

endpackage

// File: rtl/ahbw_fifo.sv
`timescale 1ns/1ps
module ahbw_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  // Storage is written on every accepted push, including one that
  // coincides with a flush.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  // A flush discards every held word; a push in the same cycle survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      rp    <= wp;
      wp    <= wp + PW'(push);
      count <= CW'(push);
    end else begin
      wp    <= wp + PW'(push);
      rp    <= rp + PW'(pop);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout = mem[rp];
  assign full = (count == CW'(DEPTH));

endmodule

// File: rtl/ahbw_data_phase.sv
`timescale 1ns/1ps
module ahbw_data_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic hready,
  input  logic hresp,
  input  logic acc,
  input  logic acc_last,
  output logic dp_active,
  output logic pop,
  output logic flush,
  output logic err_first,
  output logic done,
  output logic done_err
);

  logic dp_last;

  // The data phase of a beat begins on the edge that accepts its address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_active <= 1'b0;
      dp_last   <= 1'b0;
      done      <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      if (hready) begin
        dp_active <= acc;
        dp_last   <= acc_last;
      end
      done     <= dp_active && hready && (dp_last || hresp);
      done_err <= dp_active && hready && hresp;
    end
  end

  assign pop       = dp_active && hready && !hresp;
  assign flush     = dp_active && hready && hresp;
  assign err_first = dp_active && hresp && !hready;

endmodule

// File: rtl/ahbw_addr_seq.sv
`timescale 1ns/1ps
module ahbw_addr_seq
  import ahbw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 5,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [2:0]    cmd_size,
  input  logic          hready,
  input  logic          dp_active,
  input  logic          pop,
  input  logic          err_first,
  input  logic [CW-1:0] fifo_cnt,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic          acc,
  output logic          acc_last
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_RUN} seq_state_e;

  seq_state_e    state;
  trans_e        trans_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    size_q, burst_q;
  logic [LW:0]   left_q;     // beats not yet accepted, including the presented one
  logic [CW:0]   need;
  logic          have;
  logic [AW-1:0] step;

  assign acc      = hready && trans_q[1];
  assign acc_last = acc && (left_q == (LW+1)'(1));

  // Words already promised: one that pops now, and one for a beat accepted now.
  assign need = (CW+1)'(pop) + (CW+1)'(acc);
  assign have = ({1'b0, fifo_cnt} > need);
  assign step = AW'(1) << size_q;

  assign cmd_ready = (state == SQ_IDLE) && !dp_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= BURST_SINGLE;
      left_q  <= '0;
    end else if (err_first) begin
      trans_q <= TR_IDLE;
      state   <= SQ_IDLE;
      left_q  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_valid && cmd_ready) begin
            addr_q  <= cmd_addr;
            size_q  <= cmd_size;
            burst_q <= pick_burst(32'(cmd_len));
            left_q  <= {1'b0, cmd_len} + (LW+1)'(1);
            state   <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (hready && have) begin
            trans_q <= TR_NONSEQ;
            state   <= SQ_RUN;
          end
        end
        default: begin
          if (acc) begin
            left_q <= left_q - (LW+1)'(1);
            if (acc_last) begin
              trans_q <= TR_IDLE;
              state   <= SQ_IDLE;
            end else begin
              addr_q  <= addr_q + step;
              trans_q <= have ? TR_SEQ : TR_BUSY;
            end
          end else if (hready && trans_q == TR_BUSY) begin
            trans_q <= have ? TR_SEQ : TR_BUSY;
          end
        end
      endcase
    end
  end

  assign haddr  = addr_q;
  assign htrans = trans_q;
  assign hsize  = size_q;
  assign hburst = burst_q;

endmodule

// File: rtl/ahb_burst_writer.sv
`timescale 1ns/1ps
module ahb_burst_writer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [2:0]    cmd_size,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic          hresp,
  output logic          done,
  output logic          done_err
);

  logic          acc, acc_last, dp_active, pop, flush, err_first, full, push;
  logic [CW-1:0] fifo_cnt;
  logic [DW-1:0] head;

  assign wd_ready = !full;
  assign push     = wd_valid && wd_ready;

  ahbw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wd_data), .pop(pop),
    .flush(flush), .dout(head), .count(fifo_cnt), .full(full)
  );

  ahbw_addr_seq #(.AW(AW), .LW(LW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
    .hready(hready), .dp_active(dp_active), .pop(pop), .err_first(err_first),
    .fifo_cnt(fifo_cnt), .haddr(haddr), .htrans(htrans), .hsize(hsize),
    .hburst(hburst), .acc(acc), .acc_last(acc_last)
  );

  ahbw_data_phase u_dp (
    .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp), .acc(acc),
    .acc_last(acc_last), .dp_active(dp_active), .pop(pop), .flush(flush),
    .err_first(err_first), .done(done), .done_err(done_err)
  );

  assign hwrite = 1'b1;
  assign hwdata = dp_active ? head : '0;

endmodule

// File: rtl/ahbw_checker.sv
`timescale 1ns/1ps
module ahbw_checker
  import ahbw_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] haddr,
  input logic [1:0]    htrans,
  input logic [2:0]    hsize,
  input logic [2:0]    hburst,
  input logic          hready,
  input logic          hresp,
  input logic          done,
  input logic          done_err
);

  logic armed;  // high once a full clock cycle has passed since reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_no_seq_after_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (htrans == TR_SEQ || htrans == TR_BUSY)) |-> $past(htrans) != TR_IDLE);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && htrans == TR_SEQ && $past(htrans[1]) && $past(hready))
      |-> haddr == $past(haddr) + (AW'(1) << hsize));

  p_pause_holds_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(htrans) == TR_BUSY) |-> $stable(haddr));

  p_hold_on_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!hready && !hresp))
      |-> ($stable(htrans) && $stable(haddr) && $stable(hsize) && $stable(hburst)));

  p_idle_on_error_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(hresp && !hready)) |-> htrans == TR_IDLE);

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

endmodule

bind ahb_burst_writer ahbw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hsize(hsize),
  .hburst(hburst), .hready(hready), .hresp(hresp), .done(done), .done_err(done_err)
);

// File: tb/ahb_burst_writer_test.sv
`timescale 1ns/1ps
module ahb_burst_writer_test;
  localparam int AW = 32, DW = 32, LW = 5, DEPTH = 8;

  typedef struct packed {
    logic [31:0] addr;
    logic [5:0]  nb;
    logic [2:0]  size;
    logic [5:0]  st_at;   // 63 = no stall, data preloaded
    logic [5:0]  st_len;
    logic        wt;
    logic [2:0]  burst;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h100, 6'd4,  3'd2, 6'd63, 6'd0,  1'b0, 3'b011},
    '{32'h200, 6'd8,  3'd2, 6'd3,  6'd10, 1'b0, 3'b101},
    '{32'h300, 6'd1,  3'd0, 6'd63, 6'd0,  1'b1, 3'b000},
    '{32'h400, 6'd5,  3'd1, 6'd2,  6'd6,  1'b1, 3'b001},
    '{32'h500, 6'd16, 3'd2, 6'd8,  6'd4,  1'b0, 3'b111},
    '{32'h600, 6'd3,  3'd0, 6'd1,  6'd3,  1'b0, 3'b001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wd_valid = 1'b0, hready = 1'b1, hresp = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [2:0] cmd_size = '0;
  logic [DW-1:0] wd_data = '0;
  logic cmd_ready, wd_ready, hwrite, done, done_err;
  logic [AW-1:0] haddr;
  logic [1:0] htrans;
  logic [2:0] hsize, hburst;
  logic [DW-1:0] hwdata;

  always #2.5 clk = ~clk;

  ahb_burst_writer #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata), .hready(hready), .hresp(hresp),
    .done(done), .done_err(done_err)
  );

  int checks = 0, fails = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic final_report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] pat(input int k, input int i);
    return 32'hA500_0000 | (32'(k) << 16) | 32'(i);
  endfunction

  // ---------------- bus monitor (negedge sampling) ----------------
  bit pend = 0;
  int pend_idx = 0, acc_idx = 0, nlog = 0;
  logic [31:0] pend_addr;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [1:0]  at_tr    [64];
  logic [2:0]  at_burst [64];
  logic [2:0]  at_size  [64];
  int busy_cnt, busy_bad, hold_bad, err_idle_bad, err_beats, done_cnt, done_err_cnt;
  logic [31:0] base;
  logic [2:0] sz;
  bit p_valid = 0;
  logic p_hready, p_hresp;
  logic [1:0] p_tr;
  logic [31:0] p_addr;

  task automatic mon_reset(input logic [31:0] b, input logic [2:0] s);
    base = b; sz = s; acc_idx = 0; nlog = 0; busy_cnt = 0; busy_bad = 0;
    hold_bad = 0; err_idle_bad = 0; err_beats = 0; done_cnt = 0; done_err_cnt = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_hready && !p_hresp && (htrans !== p_tr || haddr !== p_addr))
        hold_bad++;
      if (hresp && hready && htrans != 2'b00) err_idle_bad++;
      if (htrans == 2'b01) begin
        busy_cnt++;
        if (haddr != base + (32'(acc_idx) << sz)) busy_bad++;
      end
      if (done) done_cnt++;
      if (done_err) done_err_cnt++;
      if (hready && pend) begin
        if (hresp) err_beats++;
        else if (nlog < 64) begin
          log_addr[nlog] = pend_addr;
          log_data[nlog] = hwdata;
          nlog++;
        end
        pend = 0;
      end
      if (hready && htrans[1]) begin
        pend = 1; pend_addr = haddr; pend_idx = acc_idx;
        if (acc_idx < 64) begin
          at_tr[acc_idx] = htrans; at_burst[acc_idx] = hburst; at_size[acc_idx] = hsize;
        end
        acc_idx++;
      end
      p_valid = 1; p_hready = hready; p_hresp = hresp; p_tr = htrans; p_addr = haddr;
    end
  end

  // ---------------- subordinate response driver ----------------
  bit wait_en = 0, err_armed = 0;
  int err_idx = 0, err_ph = 0, cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst_n) begin
      hready = 1'b1; hresp = 1'b0;
    end else if (err_ph == 1) begin
      hready = 1'b1; hresp = 1'b1; err_ph = 2;
    end else if (err_armed && pend && pend_idx == err_idx && err_ph == 0) begin
      hready = 1'b0; hresp = 1'b1; err_ph = 1;
    end else begin
      hresp = 1'b0;
      hready = !(wait_en && pend && cyc[0]);
    end
  end

  // ---------------- stimulus tasks (entered at posedge + 1) ----------------
  task automatic send_cmd(input logic [31:0] a, input int n, input logic [2:0] s);
    cmd_addr = a; cmd_len = LW'(n - 1); cmd_size = s; cmd_valid = 1'b1;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic feed(input int k, input int n, input int st_at, input int st_len);
    for (int i = 0; i < n; i++) begin
      if (i == st_at) begin
        wd_valid = 1'b0;
        repeat (st_len) @(posedge clk);
        #1;
      end
      wd_valid = 1'b1; wd_data = pat(k, i);
      do @(negedge clk); while (!wd_ready);
      @(posedge clk); #1;
    end
    wd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual 0 expected 1 (run hung)");
    final_report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(htrans == 2'b00, "R5", "reset htrans", htrans, 0);
    chk(cmd_ready == 1'b1, "R9", "reset cmd_ready", cmd_ready, 1);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(wd_ready == 1'b1, "R11", "reset wd_ready", wd_ready, 1);
    @(posedge clk); #1;

    // ---------- table-driven bursts ----------
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      int n;
      v = VECS[k];
      n = int'(v.nb);
      mon_reset(v.addr, v.size);
      wait_en = v.wt;
      if (v.st_at == 6'd63) begin
        feed(k, n, 99, 0);
        send_cmd(v.addr, n, v.size);
      end else begin
        fork
          feed(k, n, int'(v.st_at), int'(v.st_len));
          send_cmd(v.addr, n, v.size);
        join
      end
      wait_done();
      chk(nlog == n, "R4", "beats written", nlog, n);
      for (int i = 0; i < n && i < nlog; i++) begin
        chk(log_addr[i] == v.addr + (32'(i) << v.size), "R2", "beat address",
            log_addr[i], v.addr + (32'(i) << v.size));
        chk(log_data[i] == pat(k, i), "R7", "beat data", log_data[i], pat(k, i));
        chk(at_tr[i] == ((i == 0) ? 2'b10 : 2'b11), "R1", "beat code",
            at_tr[i], (i == 0) ? 2 : 3);
        chk(at_burst[i] == v.burst, "R8", "hburst", at_burst[i], v.burst);
        chk(at_size[i] == v.size, "R8", "hsize", at_size[i], v.size);
      end
      if (v.st_at == 6'd63) chk(busy_cnt == 0, "R5", "pause cycles without stall", busy_cnt, 0);
      else                  chk(busy_cnt > 0, "R3", "pause cycles on stall", busy_cnt, 1);
      chk(busy_bad == 0, "R3", "pause address wrong", busy_bad, 0);
      chk(hold_bad == 0, "R6", "changes during wait", hold_bad, 0);
      chk(done_cnt == 1 && done_err_cnt == 0, "R9", "done pulses", done_cnt, 1);
      chk(htrans == 2'b00, "R5", "idle after burst", htrans, 0);
      chk(hwrite == 1'b1, "R8", "hwrite", hwrite, 1);
      chk(cmd_ready == 1'b1, "R9", "ready after burst", cmd_ready, 1);
    end
    wait_en = 0;

    // ---------- empty FIFO at start: stays idle, no pause ----------
    mon_reset(32'h700, 3'd2);
    send_cmd(32'h700, 3, 3'd2);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(busy_cnt == 0 && acc_idx == 0, "R5", "activity before data", busy_cnt + acc_idx, 0);
    chk(htrans == 2'b00, "R5", "idle while empty", htrans, 0);
    chk(cmd_ready == 1'b0, "R9", "busy with pending command", cmd_ready, 0);
    @(posedge clk); #1;
    feed(10, 3, 99, 0);
    wait_done();
    chk(nlog == 3 && log_data[2] == pat(10, 2), "R7", "delayed start data", log_data[2], pat(10, 2));

    // ---------- back-pressure ----------
    mon_reset(32'h800, 3'd2);
    feed(11, 8, 99, 0);
    @(negedge clk);
    chk(wd_ready == 1'b0, "R11", "wd_ready when full", wd_ready, 0);
    @(posedge clk); #1;
    wd_valid = 1'b1; wd_data = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1 wd_valid = 1'b0;
    send_cmd(32'h800, 8, 3'd2);
    wait_done();
    chk(nlog == 8, "R11", "beats after full FIFO", nlog, 8);
    for (int i = 0; i < 8; i++)
      chk(log_data[i] == pat(11, i), "R11", "refused word not stored", log_data[i], pat(11, i));

    // ---------- error response ----------
    mon_reset(32'h900, 3'd2);
    feed(12, 4, 99, 0);
    err_armed = 1; err_idx = 1; err_ph = 0;
    send_cmd(32'h900, 4, 3'd2);
    wait_done();
    err_armed = 0;
    chk(done_cnt == 1 && done_err_cnt == 1, "R10", "error completion", done_err_cnt, 1);
    chk(nlog == 1 && err_beats == 1, "R10", "beats before error", nlog, 1);
    chk(acc_idx == 2, "R10", "no beat issued after error", acc_idx, 2);
    chk(err_idle_bad == 0, "R10", "idle in second error cycle", err_idle_bad, 0);
    chk(htrans == 2'b00, "R10", "idle after error", htrans, 0);
    err_ph = 0;

    mon_reset(32'hA00, 3'd2);
    feed(13, 2, 99, 0);
    send_cmd(32'hA00, 2, 3'd2);
    wait_done();
    chk(nlog == 2 && log_data[0] == pat(13, 0), "R10", "leftover words discarded",
        log_data[0], pat(13, 0));
    chk(done_err_cnt == 0, "R9", "clean completion after error", done_err_cnt, 0);

    final_report();
  end

endmodule